// File: doc/BRIEF.md
# Charger Safety Timer Unit

This block supervises the time a battery charger may spend in its charging states. It holds four independent timers (watchdog, charge, USB and wake-up) that advance on a shared slow tick. Each timer runs, holds and clears under its own charger condition. The charge timer's limit follows the current charge phase. The charger state machine feeds in its state classes, and the register block feeds in a write strobe, a clear command and the control bits. Register decoding is not part of this block.

When any timer reaches its limit, the block raises a one-cycle timeout pulse toward the state machine. It also sets a sticky per-timer status bit, which the next register write clears. Every duration is a number of seconds times a ticks-per-second parameter, so the whole time scale can be compressed. All ports are plain control and status levels or strobes. No streaming data crosses the boundary, so no valid/ready handshake applies.

Top module: `chg_safety_timers`

## Requirements
- R1: After reset, `timeout_o` is 0 and `to_stat_o` is 4'b0000. Status bit positions are [0] watchdog, [1] charge, [2] USB and [3] wake-up.
- R2: The watchdog does not run until the first `reg_wr_i` pulse. Every write restarts it from zero. It expires after WD_SEC*TICKS_PER_SEC counted ticks.
- R3: The watchdog counts only while `st_active_i` or `st_fault_i` is high. While `wd_dis_i` is high it neither counts nor expires.
- R4: The charge timer limit is 1 h in the constant-current phase (`ph_cc_i`). In the constant-voltage phase (`ph_cv_i`) it is 2 h when `cv_short_i` is 0 and 1 h when it is 1. In all other active states it is 3 h. One hour is CHG_HOUR_SEC*TICKS_PER_SEC ticks.
- R5: The charge timer counts only while `st_active_i` is high and `chg_dis_i` is low. Outside those conditions it holds its count. `tmr_clr_i` clears it.
- R6: The USB timer counts only while `st_active_i` and `low_lim_i` are both high. It holds its count otherwise. It clears on `st_off_i` or `tmr_clr_i`. It expires after USB_SEC*TICKS_PER_SEC ticks.
- R7: The wake-up timer counts only while `low_lim_i` is high in the weak-wait or weak-safe state. It holds its count in other states. It clears whenever `low_lim_i` is low. It expires after WU_SEC*TICKS_PER_SEC ticks.
- R8: An expiry raises `timeout_o` for exactly one cycle, in the cycle after the clock edge that counted the final tick. The matching `to_stat_o` bit is set one cycle later and stays set until the next `reg_wr_i` pulse. If an expiry and a write arrive in the same cycle, the set wins.
- R9: An expired timer does not pulse again until it has been cleared or restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Slow time-base tick, one cycle wide |
| st_active_i | input | 1 | Charger is in an active state |
| st_fault_i | input | 1 | Charger is in the fault state |
| st_off_i | input | 1 | Charger is in the off state |
| st_weak_wait_i | input | 1 | Charger is in weak-wait |
| st_weak_safe_i | input | 1 | Charger is in weak-safe |
| ph_cc_i | input | 1 | Constant-current phase |
| ph_cv_i | input | 1 | Constant-voltage phase |
| reg_wr_i | input | 1 | Register write strobe |
| tmr_clr_i | input | 1 | Charge/USB timer clear command |
| wd_dis_i | input | 1 | Watchdog disable |
| chg_dis_i | input | 1 | Charge timer disable |
| cv_short_i | input | 1 | Selects the 1 h constant-voltage limit |
| low_lim_i | input | 1 | Lowest input current limit is selected |
| timeout_o | output | 1 | One-cycle expiry pulse |
| to_stat_o | output | 4 | Sticky per-timer expiry status |

## Verification
The bench targets the following corner cases:
- Watchdog before the first write: a design that arms the watchdog at reset would time out with no write at all.
- Write one tick before expiry: a design that ignores restarts would fire early.
- Charge timer across an inactive gap: a timer that clears when it halts would fire late, and one that keeps counting would fire early.
- Constant-voltage select bit: each charge phase is checked for the exact tick of expiry, so a swapped select bit shows up directly.
- USB timer cleared by the off state: a clear that fails would show up as an early USB expiry.
- Wake-up timer cleared by the input limit rising: a clear that fails would show up as an early wake-up expiry.
- Unexpected pulses: any pulse outside an expected window, or a wrong status mask, is reported.

// File: rtl/sft_pkg.sv
package sft_pkg;
  localparam int NTMR = 4;
  typedef enum int {
    T_WD  = 0,
    T_CHG = 1,
    T_USB = 2,
    T_WU  = 3
  } tmr_idx_e;
endpackage

// File: rtl/sft_tmr_cnt.sv
module sft_tmr_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic          clr_i,
  input  logic [CW-1:0] limit_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic          done_q;

  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      done_q   <= 1'b0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (clr_i) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (run_i && tick_i && !done_q) begin
        cnt_q <= cnt_nxt;
        if (cnt_nxt >= limit_i) begin
          done_q   <= 1'b1;
          expire_o <= 1'b1;
        end
      end
    end
  end

  // R9
  exp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o);
  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr_i) |=> (done_q && !expire_o));
  // R5
  halt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/sft_ctrl.sv
module sft_ctrl
  import sft_pkg::*;
#(
  parameter int CW           = 8,
  parameter int WD_LIM       = 4,
  parameter int HOUR_LIM     = 4,
  parameter int USB_LIM      = 4,
  parameter int WU_LIM       = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     st_active_i,
  input  logic                     st_fault_i,
  input  logic                     st_off_i,
  input  logic                     st_weak_wait_i,
  input  logic                     st_weak_safe_i,
  input  logic                     ph_cc_i,
  input  logic                     ph_cv_i,
  input  logic                     reg_wr_i,
  input  logic                     tmr_clr_i,
  input  logic                     wd_dis_i,
  input  logic                     chg_dis_i,
  input  logic                     cv_short_i,
  input  logic                     low_lim_i,
  output logic [NTMR-1:0]          run_o,
  output logic [NTMR-1:0]          clr_o,
  output logic [NTMR-1:0][CW-1:0]  limit_o
);
  localparam logic [CW-1:0] L_WD  = CW'(WD_LIM);
  localparam logic [CW-1:0] L_1H  = CW'(HOUR_LIM);
  localparam logic [CW-1:0] L_2H  = CW'(2 * HOUR_LIM);
  localparam logic [CW-1:0] L_3H  = CW'(3 * HOUR_LIM);
  localparam logic [CW-1:0] L_USB = CW'(USB_LIM);
  localparam logic [CW-1:0] L_WU  = CW'(WU_LIM);

  logic armed_q;
  logic [CW-1:0] chg_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else if (reg_wr_i) armed_q <= 1'b1;
  end

  always_comb begin
    if (ph_cc_i)      chg_lim = L_1H;
    else if (ph_cv_i) chg_lim = cv_short_i ? L_1H : L_2H;
    else              chg_lim = L_3H;
  end

  always_comb begin
    run_o[T_WD]  = armed_q && !wd_dis_i && (st_active_i || st_fault_i);
    clr_o[T_WD]  = reg_wr_i || wd_dis_i;
    run_o[T_CHG] = st_active_i && !chg_dis_i;
    clr_o[T_CHG] = tmr_clr_i;
    run_o[T_USB] = st_active_i && low_lim_i;
    clr_o[T_USB] = tmr_clr_i || st_off_i;
    run_o[T_WU]  = low_lim_i && (st_weak_wait_i || st_weak_safe_i);
    clr_o[T_WU]  = !low_lim_i;
    limit_o[T_WD]  = L_WD;
    limit_o[T_CHG] = chg_lim;
    limit_o[T_USB] = L_USB;
    limit_o[T_WU]  = L_WU;
  end

  // R2
  wd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !run_o[T_WD]);
  // R3
  wd_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_o[T_WD] |-> (st_active_i || st_fault_i));
endmodule

// File: rtl/sft_status.sv
module sft_status
  import sft_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTMR-1:0] expire_i,
  input  logic            reg_wr_i,
  output logic            timeout_o,
  output logic [NTMR-1:0] stat_o
);
  assign timeout_o = |expire_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_o <= '0;
    else stat_o <= (reg_wr_i ? '0 : stat_o) | expire_i;
  end

  // R8
  pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> ($countones(stat_o) > 0));
  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr_i && !timeout_o) |=> $stable(stat_o));
endmodule

// File: rtl/chg_safety_timers.sv
module chg_safety_timers
  import sft_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32,
  parameter int WD_SEC        = 32,
  parameter int CHG_HOUR_SEC  = 3600,
  parameter int USB_SEC       = 2048,
  parameter int WU_SEC        = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       st_active_i,
  input  logic       st_fault_i,
  input  logic       st_off_i,
  input  logic       st_weak_wait_i,
  input  logic       st_weak_safe_i,
  input  logic       ph_cc_i,
  input  logic       ph_cv_i,
  input  logic       reg_wr_i,
  input  logic       tmr_clr_i,
  input  logic       wd_dis_i,
  input  logic       chg_dis_i,
  input  logic       cv_short_i,
  input  logic       low_lim_i,
  output logic       timeout_o,
  output logic [3:0] to_stat_o
);
  localparam int WD_LIM   = WD_SEC * TICKS_PER_SEC;
  localparam int HOUR_LIM = CHG_HOUR_SEC * TICKS_PER_SEC;
  localparam int USB_LIM  = USB_SEC * TICKS_PER_SEC;
  localparam int WU_LIM   = WU_SEC * TICKS_PER_SEC;
  localparam int M1 = (WD_LIM > 3 * HOUR_LIM) ? WD_LIM : 3 * HOUR_LIM;
  localparam int M2 = (USB_LIM > WU_LIM) ? USB_LIM : WU_LIM;
  localparam int LIM_MAX = (M1 > M2) ? M1 : M2;
  localparam int CW = $clog2(LIM_MAX + 2);

  logic [NTMR-1:0]         run;
  logic [NTMR-1:0]         clr;
  logic [NTMR-1:0][CW-1:0] limit;
  logic [NTMR-1:0]         expire;

  sft_ctrl #(
    .CW(CW), .WD_LIM(WD_LIM), .HOUR_LIM(HOUR_LIM),
    .USB_LIM(USB_LIM), .WU_LIM(WU_LIM)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .st_active_i(st_active_i), .st_fault_i(st_fault_i),
    .st_off_i(st_off_i), .st_weak_wait_i(st_weak_wait_i),
    .st_weak_safe_i(st_weak_safe_i), .ph_cc_i(ph_cc_i),
    .ph_cv_i(ph_cv_i), .reg_wr_i(reg_wr_i), .tmr_clr_i(tmr_clr_i),
    .wd_dis_i(wd_dis_i), .chg_dis_i(chg_dis_i),
    .cv_short_i(cv_short_i), .low_lim_i(low_lim_i),
    .run_o(run), .clr_o(clr), .limit_o(limit)
  );

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    sft_tmr_cnt #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .run_i(run[g]), .clr_i(clr[g]), .limit_i(limit[g]),
      .expire_o(expire[g])
    );
  end

  sft_status u_stat (
    .clk(clk), .rst_n(rst_n), .expire_i(expire),
    .reg_wr_i(reg_wr_i), .timeout_o(timeout_o), .stat_o(to_stat_o)
  );

  // R3
  wd_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_dis_i && $past(wd_dis_i)) |-> !expire[T_WD]);
endmodule

// File: tb/tb_chg_safety_timers.sv
module tb_chg_safety_timers;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 0, st_active_i = 0, st_fault_i = 0, st_off_i = 0;
  logic st_weak_wait_i = 0, st_weak_safe_i = 0, ph_cc_i = 0, ph_cv_i = 0;
  logic reg_wr_i = 0, tmr_clr_i = 0, wd_dis_i = 1, chg_dis_i = 1;
  logic cv_short_i = 0, low_lim_i = 0;
  logic timeout_o;
  logic [3:0] to_stat_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;
  logic [3:0] expq[$];

  always #10 clk = ~clk;

  chg_safety_timers #(
    .TICKS_PER_SEC(2), .WD_SEC(4), .CHG_HOUR_SEC(3), .USB_SEC(6), .WU_SEC(5)
  ) dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      tick_i = 1'b1;
      @(negedge clk);
    end
    tick_i = 1'b0;
  endtask

  task automatic pulse_wr();
    reg_wr_i = 1'b1; @(negedge clk); reg_wr_i = 1'b0;
  endtask

  task automatic pulse_clr();
    tmr_clr_i = 1'b1; @(negedge clk); tmr_clr_i = 1'b0;
  endtask

  // driver: n-1 ticks, then push expected mask, then the final tick
  task automatic expect_at(input int n, input logic [3:0] m, input string tag);
    ticks(n - 1);
    expq.push_back(m);
    ticks(1);
    idle(3);
    chk(expq.size() == 0, tag, expq.size(), 0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && timeout_o) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R8 unexpected timeout", {28'd0, to_stat_o}, 0);
      end else begin
        logic [3:0] m;
        m = expq.pop_front();
        @(negedge clk);
        chk(to_stat_o == m, "R8 status mask", to_stat_o, m);
        chk(!timeout_o, "R8 single-cycle pulse", timeout_o, 0);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=<50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk(timeout_o == 0 && to_stat_o == 0, "R1 reset state", to_stat_o, 0);
    rst_n = 1'b1;
    idle(2);

    // R2 watchdog idle before first write, restart on write
    wd_dis_i = 0; st_active_i = 1;
    ticks(20); idle(2);
    chk(to_stat_o == 0, "R2 no start before write", to_stat_o, 0);
    pulse_wr();
    ticks(7);
    pulse_wr();
    expect_at(8, 4'b0001, "R2 watchdog expiry after restart");
    ticks(20); idle(2);
    chk(to_stat_o == 4'b0001, "R9 no repeat expiry", to_stat_o, 1);
    pulse_wr(); idle(1);
    chk(to_stat_o == 0, "R8 write clears sticky", to_stat_o, 0);
    // R3 state gating
    st_active_i = 0;
    ticks(20); idle(2);
    chk(to_stat_o == 0, "R3 halted outside active/fault", to_stat_o, 0);
    st_fault_i = 1;
    expect_at(8, 4'b0001, "R3 watchdog runs in fault");
    st_fault_i = 0; st_active_i = 1;
    wd_dis_i = 1; pulse_wr();
    ticks(20); idle(2);
    chk(to_stat_o == 0, "R3 disabled watchdog", to_stat_o, 0);

    // R4/R5 charge timer
    chg_dis_i = 0; pulse_clr();
    ticks(17);
    st_active_i = 0; ticks(5); st_active_i = 1;
    expect_at(1, 4'b0010, "R5 3h limit with hold across inactive");
    pulse_clr(); pulse_wr();
    ph_cc_i = 1;
    expect_at(6, 4'b0010, "R4 constant-current 1h");
    pulse_clr(); pulse_wr();
    ph_cc_i = 0; ph_cv_i = 1; cv_short_i = 0;
    expect_at(12, 4'b0010, "R4 constant-voltage 2h");
    pulse_clr(); pulse_wr();
    cv_short_i = 1;
    expect_at(6, 4'b0010, "R4 constant-voltage short 1h");
    ph_cv_i = 0; chg_dis_i = 1; pulse_clr(); pulse_wr();
    ticks(25); idle(2);
    chk(to_stat_o == 0, "R5 charge disable", to_stat_o, 0);

    // R6 USB timer
    low_lim_i = 1;
    expect_at(12, 4'b0100, "R6 USB expiry");
    pulse_clr(); pulse_wr();
    ticks(10);
    st_active_i = 0; st_off_i = 1; idle(1); st_off_i = 0; st_active_i = 1;
    expect_at(12, 4'b0100, "R6 off state clears USB");
    pulse_clr(); pulse_wr();
    ticks(6); low_lim_i = 0; ticks(10); low_lim_i = 1;
    ticks(3); st_active_i = 0; ticks(5); st_active_i = 1;
    expect_at(3, 4'b0100, "R6 holds when limit raised or inactive");
    pulse_clr(); pulse_wr();

    // R7 wake-up timer
    st_active_i = 0; st_weak_wait_i = 1;
    expect_at(10, 4'b1000, "R7 wake-up expiry");
    pulse_wr();
    low_lim_i = 0; idle(1); low_lim_i = 1;
    ticks(5);
    st_weak_wait_i = 0; st_weak_safe_i = 1; ticks(2);
    st_weak_safe_i = 0; ticks(6); st_weak_safe_i = 1;
    expect_at(3, 4'b1000, "R7 clear on limit rise, hold across states");
    low_lim_i = 0; idle(1); low_lim_i = 1;
    ticks(9); low_lim_i = 0; idle(1); low_lim_i = 1;
    ticks(9); idle(2);
    chk(to_stat_o == 4'b1000, "R7 clear restarts count", to_stat_o, 8);
    low_lim_i = 0; st_weak_safe_i = 0; pulse_wr(); idle(1);
    chk(to_stat_o == 0 && expq.size() == 0, "R8 final clear", to_stat_o, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule